// File: doc/BRIEF.md
# Display Identification Block Fetch Engine

This engine pulls the 128-byte display identification block from an attached monitor through a simple byte-read transaction port and decides whether the block can be used. A single `go` pulse starts a fetch. The engine walks the block from offset 0 in ascending chunks. Each chunk is preceded by a one-cycle queue flush. The returned bytes are written into a local 128-byte buffer while a running modulo-256 sum is kept. When the last chunk lands, the engine checks the sum, the version fields and the four detailed-timing slots, and it ends with a one-cycle `done` pulse.

If a transaction stalls, or if the block sum is wrong, the whole block is fetched again, up to three attempts in total. A stalled transaction is one in which the link stays busy for a fifth of a second, counted in clock cycles from `CLK_HZ`. A host reads the fetched bytes afterwards through a registered read port. The bit-level two-wire master that serves the transaction port and the decoding of timing descriptors sit outside this block.

Top module: `edid_fetch`

## Requirements
- R1: A fetch reads offsets 0 to 127 in ascending, contiguous transactions of `min(CHUNK_MAX, 128 - offset)` bytes each (`CHUNK_MAX` is at most 16), so the last transaction carries the remainder. Every new attempt restarts at offset 0.
- R2: Each transaction presents `txn_seg` = offset >> 8 (always 0 for this block) and `txn_off` = offset bits 7:0, held while `txn_start` is high.
- R3: `fifo_clr` is high for exactly the one cycle before every `txn_start` pulse. No transaction starts until `txn_busy` of the previous one has returned to 0.
- R4: If `txn_busy` is still high after `CLK_HZ/5` cycles of waiting, the attempt fails. The next `fifo_clr` (retry) or `done` (last attempt) appears `CLK_HZ/5 + 1` cycles after that transaction's `txn_start`. A final failure of this kind reports `err_code` 0.
- R5: An attempt whose 128 bytes do not sum to 0 modulo 256 fails. A failed attempt restarts the whole block, up to 3 attempts in total. After the third failure, `err_code` is 1 when the last failure was a sum error and 0 when it was a stall.
- R6: A block with a correct sum is accepted only when byte 18 equals 1 and either byte 19 is at least 3 or bit 1 of byte 24 is set. Otherwise `err` is raised with `err_code` 2. This test takes precedence over R7.
- R7: The slots at bytes 54, 72, 90 and 108 are examined in that order. A slot is usable when the 16-bit word at its first two bytes is nonzero, and the other slot bytes play no part. `slot_idx` gives the first usable slot (0 to 3). If no slot is usable, `err` is raised with `err_code` 3.
- R8: `done` is a single-cycle pulse, once per fetch. `err`, `err_code` and `slot_idx` are valid in that cycle and hold until the next fetch ends. On an error `slot_idx` is 0, and on success `err_code` is 0. After reset `done`, `fifo_clr` and `txn_start` are 0.
- R9: `rd_data` returns the buffer byte at `rd_addr` one cycle later. After a successful fetch the buffer holds the 128 bytes as received.
- R10: A `go` pulse while a fetch is in progress is ignored, and that fetch continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a fetch (accepted only when idle) |
| done | output | 1 | One-cycle end-of-fetch pulse |
| err | output | 1 | Fetch failed (valid with done) |
| err_code | output | 2 | 0 stall, 1 sum, 2 version, 3 no usable slot |
| slot_idx | output | 2 | Chosen timing slot (valid with done) |
| fifo_clr | output | 1 | Flush the link's receive queue |
| txn_start | output | 1 | Start one read transaction |
| txn_seg | output | 8 | Segment number of the transaction |
| txn_off | output | 8 | Low offset byte of the transaction |
| txn_len | output | 5 | Byte count of the transaction |
| txn_busy | input | 1 | Link is executing a transaction |
| rx_valid | input | 1 | A received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| rd_addr | input | 7 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |

## Verification
The bench runs with a 12-byte chunk so that the final 8-byte remainder is exercised, and it checks every transaction's offset, length and segment against a running model. A wrong split shows up there as a misplaced offset or an extra transaction. The bench sweeps all 16 patterns of live slots, with the live word carried alternately in its low or its high byte, while filling the non-clock bytes of dead slots. An engine that tests only one byte, or any slot byte, would then pick the wrong slot. It also sweeps version, revision and the feature flag, so that the boundary at revision 3 and the precedence of the version test over the slot test are both exposed. Stall and sum faults are injected per attempt, and the bench checks the exact timeout distance, the retry count and which cause is reported when all three attempts fail. An engine that re-reads only the failing chunk, stops after two attempts, or reports the first cause instead of the last would be caught by these checks.

// File: rtl/edid_fetch_pkg.sv
// Shared constants and types for the identification block fetch engine.
// Assumes a fixed 128-byte block; byte positions are those the validation
// rules depend on.
package edid_fetch_pkg;
    localparam int BLOCK_BYTES = 128;
    localparam int IDX_W       = $clog2(BLOCK_BYTES);
    localparam int VER_POS     = 18;
    localparam int REV_POS     = 19;
    localparam int FEAT_POS    = 24;
    localparam int FEAT_BIT    = 1;
    localparam int MIN_REV     = 3;
    localparam int SLOT_CNT    = 4;
    localparam int SLOT_BASE   = 54;
    localparam int SLOT_STRIDE = 18;

    typedef enum logic [1:0] {
        ERR_TMO    = 2'd0,
        ERR_CSUM   = 2'd1,
        ERR_VER    = 2'd2,
        ERR_NOSLOT = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_START,
        ST_WAIT,
        ST_CHECK
    } seq_e;
endpackage

// File: rtl/edid_xfer_ctl.sv
// Transaction address generator and stall timer.
// Holds the running block offset, derives the chunk length (capped at
// CHUNK_MAX, remainder at the end) and counts cycles of a busy link.
// Assumes CHUNK_MAX is between 1 and 16 and CLK_HZ is at least 5.
module edid_xfer_ctl
    import edid_fetch_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int CHUNK_MAX = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        advance,
    input  logic        tmo_clr,
    input  logic        tmo_run,
    output logic [15:0] off,
    output logic [4:0]  len,
    output logic        last,
    output logic        tmo_hit
);
    localparam int TMO_CYC = (CLK_HZ / 5 < 1) ? 1 : CLK_HZ / 5;
    localparam int TMO_W   = $clog2(TMO_CYC + 1);

    logic [15:0]      off_q;
    logic [15:0]      remain;
    logic [TMO_W-1:0] tmo_q;

    // Chunk length and last-chunk flag from the current offset.
    always_comb begin
        remain = 16'(BLOCK_BYTES) - off_q;
        if (remain < 16'(CHUNK_MAX)) begin
            len = remain[4:0];
        end else begin
            len = 5'(CHUNK_MAX);
        end
        last = (off_q + 16'(len)) == 16'(BLOCK_BYTES);
    end

    // Running offset: back to zero at each attempt, forward per chunk.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            off_q <= '0;
        end else if (advance) begin
            off_q <= off_q + 16'(len);
        end
    end

    // Stall timer: counts waiting cycles while the link stays busy.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo_clr) begin
            tmo_q <= '0;
        end else if (tmo_run && !tmo_hit) begin
            tmo_q <= tmo_q + 1'b1;
        end
    end

    assign tmo_hit = tmo_run && (tmo_q == TMO_W'(TMO_CYC - 1));
    assign off     = off_q;
endmodule

// File: rtl/edid_store.sv
// Block buffer with running sum and field capture.
// Writes received bytes into a 128-entry array, keeps the modulo-256 sum
// of the current attempt and captures the version, revision, feature flag
// and per-slot "clock word nonzero" flags as they pass.
// Assumes each address is written once per attempt.
module edid_store
    import edid_fetch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [IDX_W-1:0]    rd_addr,
    output logic [7:0]          rd_data,
    output logic                sum_ok,
    output logic [7:0]          ver,
    output logic [7:0]          rev,
    output logic                feat,
    output logic [SLOT_CNT-1:0] live
);
    logic [7:0] mem_q [BLOCK_BYTES];
    logic [7:0] sum_q;

    // Buffer write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Registered buffer read port.
    always_ff @(posedge clk) begin
        rd_data <= mem_q[rd_addr];
    end

    // Running sum of the bytes of the current attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
        end else if (wr_en) begin
            sum_q <= sum_q + wr_data;
        end
    end

    // Capture of the version fields as their bytes are written.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ver  <= '0;
            rev  <= '0;
            feat <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == IDX_W'(VER_POS))  ver  <= wr_data;
            if (wr_addr == IDX_W'(REV_POS))  rev  <= wr_data;
            if (wr_addr == IDX_W'(FEAT_POS)) feat <= wr_data[FEAT_BIT];
        end
    end

    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
        localparam int LO = SLOT_BASE + s * SLOT_STRIDE;
        logic hit_q;
        // Slot flag: set when either byte of its clock word is nonzero.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                hit_q <= 1'b0;
            end else if (wr_en && (wr_data != 8'd0) &&
                         ((wr_addr == IDX_W'(LO)) || (wr_addr == IDX_W'(LO + 1)))) begin
                hit_q <= 1'b1;
            end
        end
        assign live[s] = hit_q;
    end

    assign sum_ok = (sum_q == 8'd0);
endmodule

// File: rtl/edid_judge.sv
// Block acceptance logic (combinational).
// Decides whether the captured version fields are acceptable and picks the
// lowest-numbered usable timing slot. Assumes the captures are final.
module edid_judge
    import edid_fetch_pkg::*;
(
    input  logic [7:0]          ver,
    input  logic [7:0]          rev,
    input  logic                feat,
    input  logic [SLOT_CNT-1:0] live,
    output logic                ver_ok,
    output logic                found,
    output logic [1:0]          idx
);
    // Version rule: major 1, and a new enough revision or the feature flag.
    always_comb begin
        ver_ok = (ver == 8'd1) && ((rev >= 8'(MIN_REV)) || feat);
    end

    // Priority pick of the first usable slot.
    always_comb begin
        found = 1'b0;
        idx   = 2'd0;
        for (int s = SLOT_CNT - 1; s >= 0; s--) begin
            if (live[s]) begin
                found = 1'b1;
                idx   = 2'(s);
            end
        end
    end
endmodule

// File: rtl/edid_fetch.sv
// Identification block fetch engine (top).
// Sequences flush / start / wait per chunk, retries the whole block on a
// stall or a bad sum up to MAX_TRIES attempts, then validates and reports
// with a one-cycle done pulse. Assumes the link raises txn_busy no later
// than the cycle after txn_start and streams rx bytes while busy.
module edid_fetch
    import edid_fetch_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int CHUNK_MAX = 16,
    parameter int MAX_TRIES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    output logic       done,
    output logic       err,
    output logic [1:0] err_code,
    output logic [1:0] slot_idx,
    output logic       fifo_clr,
    output logic       txn_start,
    output logic [7:0] txn_seg,
    output logic [7:0] txn_off,
    output logic [4:0] txn_len,
    input  logic       txn_busy,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic [6:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_e               st_q;
    logic [TRY_W-1:0]   tries_q;
    logic [15:0]        off;
    logic [4:0]         len;
    logic               last;
    logic               tmo_hit;
    logic [IDX_W-1:0]   wr_ptr_q;
    logic [4:0]         rx_cnt_q;
    logic               wr_en;
    logic               launch;
    logic               att_fail;
    logic               final_try;
    logic               retry;
    logic               restart;
    logic               advance;
    err_e               fail_code;
    logic               sum_ok;
    logic [7:0]         ver;
    logic [7:0]         rev;
    logic               feat;
    logic [SLOT_CNT-1:0] live;
    logic               ver_ok;
    logic               found;
    logic [1:0]         idx;

    // Attempt-level decisions taken in the current cycle.
    always_comb begin
        launch    = (st_q == ST_IDLE) && go;
        att_fail  = ((st_q == ST_WAIT) && txn_busy && tmo_hit) ||
                    ((st_q == ST_CHECK) && !sum_ok);
        fail_code = (st_q == ST_WAIT) ? ERR_TMO : ERR_CSUM;
        final_try = (tries_q == TRY_W'(MAX_TRIES - 1));
        retry     = att_fail && !final_try;
        restart   = launch || retry;
        advance   = (st_q == ST_WAIT) && !txn_busy && !last;
        wr_en     = (st_q == ST_WAIT) && rx_valid && (rx_cnt_q < len);
    end

    u_xfer_dummy_guard: assert final (CHUNK_MAX >= 1 && CHUNK_MAX <= 16);

    edid_xfer_ctl #(
        .CLK_HZ   (CLK_HZ),
        .CHUNK_MAX(CHUNK_MAX)
    ) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .advance(advance),
        .tmo_clr(st_q == ST_START),
        .tmo_run((st_q == ST_WAIT) && txn_busy),
        .off    (off),
        .len    (len),
        .last   (last),
        .tmo_hit(tmo_hit)
    );

    edid_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .wr_en  (wr_en),
        .wr_addr(wr_ptr_q),
        .wr_data(rx_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .sum_ok (sum_ok),
        .ver    (ver),
        .rev    (rev),
        .feat   (feat),
        .live   (live)
    );

    edid_judge u_judge (
        .ver   (ver),
        .rev   (rev),
        .feat  (feat),
        .live  (live),
        .ver_ok(ver_ok),
        .found (found),
        .idx   (idx)
    );

    // Sequencer state and attempt counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            tries_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        tries_q <= '0;
                        st_q    <= ST_CLR;
                    end
                end
                ST_CLR:   st_q <= ST_START;
                ST_START: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (!txn_busy) begin
                        st_q <= last ? ST_CHECK : ST_CLR;
                    end else if (tmo_hit) begin
                        st_q <= final_try ? ST_IDLE : ST_CLR;
                    end
                end
                ST_CHECK: begin
                    if (sum_ok || final_try) begin
                        st_q <= ST_IDLE;
                    end else begin
                        st_q <= ST_CLR;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
            if (retry) begin
                tries_q <= tries_q + 1'b1;
            end
        end
    end

    // Write pointer and received-byte count of the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rx_cnt_q <= '0;
        end else if (st_q == ST_START) begin
            wr_ptr_q <= off[IDX_W-1:0];
            rx_cnt_q <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
            rx_cnt_q <= rx_cnt_q + 1'b1;
        end
    end

    // Result registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= 2'd0;
            slot_idx <= 2'd0;
        end else begin
            done <= 1'b0;
            if (att_fail && final_try) begin
                done     <= 1'b1;
                err      <= 1'b1;
                err_code <= fail_code;
                slot_idx <= 2'd0;
            end else if ((st_q == ST_CHECK) && sum_ok) begin
                done <= 1'b1;
                if (!ver_ok) begin
                    err      <= 1'b1;
                    err_code <= ERR_VER;
                    slot_idx <= 2'd0;
                end else if (!found) begin
                    err      <= 1'b1;
                    err_code <= ERR_NOSLOT;
                    slot_idx <= 2'd0;
                end else begin
                    err      <= 1'b0;
                    err_code <= 2'd0;
                    slot_idx <= idx;
                end
            end
        end
    end

    assign fifo_clr  = (st_q == ST_CLR);
    assign txn_start = (st_q == ST_START);
    assign txn_seg   = off[15:8];
    assign txn_off   = off[7:0];
    assign txn_len   = len;
endmodule

// File: rtl/edid_fetch_chk.sv
// Protocol checker for the fetch engine, attached by bind.
// Watches the transaction port and the done pulse only.
module edid_fetch_chk #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int CHUNK_MAX = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       fifo_clr,
    input logic       txn_start,
    input logic [7:0] txn_seg,
    input logic [7:0] txn_off,
    input logic [4:0] txn_len,
    input logic       txn_busy
);
    localparam int LIM = CLK_HZ / 5 + 2;
    localparam int CW  = $clog2(LIM + 2);

    logic [CW-1:0] busy_run;

    // Cycles of busy link since the last transaction start (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || txn_start) begin
            busy_run <= '0;
        end else if (txn_busy && (busy_run != CW'(LIM + 1))) begin
            busy_run <= busy_run + 1'b1;
        end
    end

    p_chunk_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> (txn_len != 5'd0) && (txn_len <= 5'(CHUNK_MAX)) &&
                      (({1'b0, txn_off} + 9'(txn_len)) <= 9'd128));

    p_segment_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> (txn_seg == 8'd0));

    p_clear_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> $past(fifo_clr));

    p_stall_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr || done) |-> (busy_run <= CW'(LIM)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind edid_fetch edid_fetch_chk #(
    .CLK_HZ   (CLK_HZ),
    .CHUNK_MAX(CHUNK_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .fifo_clr (fifo_clr),
    .txn_start(txn_start),
    .txn_seg  (txn_seg),
    .txn_off  (txn_off),
    .txn_len  (txn_len),
    .txn_busy (txn_busy)
);

// File: tb/edid_fetch_bench.sv
// Self-checking bench: link model with per-attempt stall and corruption,
// sweeps over slot patterns and version fields, retry cases and readback.
module edid_fetch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 500;
    localparam int TMO        = HZ / 5;
    localparam int CHUNK      = 12;
    localparam int BLK        = 128;
    localparam int NCHUNK     = (BLK + CHUNK - 1) / CHUNK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic       done, err, fifo_clr, txn_start;
    logic [1:0] err_code, slot_idx;
    logic [7:0] txn_seg, txn_off, rx_data = 8'd0, rd_data;
    logic [4:0] txn_len;
    logic       txn_busy = 1'b0, rx_valid = 1'b0;
    logic [6:0] rd_addr = 7'd0;

    int checks = 0;
    int errors = 0;

    logic [7:0] img [BLK];
    logic [2:0] hang_mask = 3'b000;
    logic [2:0] bad_mask  = 3'b000;
    int cur_ver, cur_rev, cur_feat, cur_mask;

    // monitor state
    int  cyc = 0, starts = 0, dones = 0, mon_att = 0, exp_off = 0;
    int  start_cyc = 0, hang_gap = -1;
    bit  prev_clr = 1'b0, hung_pend = 1'b0;
    logic       d_err;
    logic [1:0] d_code, d_slot;
    int  latt = 0;

    edid_fetch #(
        .CLK_HZ   (HZ),
        .CHUNK_MAX(CHUNK),
        .MAX_TRIES(3)
    ) u_edid_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .done(done), .err(err),
        .err_code(err_code), .slot_idx(slot_idx), .fifo_clr(fifo_clr),
        .txn_start(txn_start), .txn_seg(txn_seg), .txn_off(txn_off),
        .txn_len(txn_len), .txn_busy(txn_busy), .rx_valid(rx_valid),
        .rx_data(rx_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    // Transaction and done monitor, sampled mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (done) begin
                    dones++;
                    d_err  = err;
                    d_code = err_code;
                    d_slot = slot_idx;
                    if (hung_pend) begin hang_gap = cyc - start_cyc; hung_pend = 1'b0; end
                end
                if (fifo_clr && hung_pend) begin
                    hang_gap  = cyc - start_cyc;
                    hung_pend = 1'b0;
                end
                if (txn_start) begin
                    int el;
                    starts++;
                    if (exp_off == 0) mon_att++;
                    el = (BLK - exp_off < CHUNK) ? BLK - exp_off : CHUNK;
                    chk(prev_clr, "R3 clear before start", int'(prev_clr), 1);
                    chk(int'(txn_off) == exp_off, "R1 offset", int'(txn_off), exp_off);
                    chk(int'(txn_len) == el, "R1 length", int'(txn_len), el);
                    chk(txn_seg == 8'd0, "R2 segment", int'(txn_seg), 0);
                    start_cyc = cyc;
                    if (mon_att >= 1 && mon_att <= 3 && hang_mask[mon_att-1]) begin
                        hung_pend = 1'b1;
                        exp_off   = 0;
                    end else begin
                        exp_off = exp_off + el;
                        if (exp_off >= BLK) exp_off = 0;
                    end
                end
                prev_clr = fifo_clr;
            end
        end
    end

    // Link model: answers each transaction from img, with injected faults.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txn_start) begin
                int o, n;
                bit hang, bad;
                if (txn_off == 8'd0) latt++;
                o = int'(txn_off);
                n = int'(txn_len);
                hang = (latt >= 1 && latt <= 3) ? hang_mask[latt-1] : 1'b0;
                bad  = (latt >= 1 && latt <= 3) ? bad_mask[latt-1]  : 1'b0;
                txn_busy = 1'b1;
                if (hang) begin
                    do @(negedge clk); while (!(fifo_clr || done));
                    txn_busy = 1'b0;
                end else begin
                    for (int i = 0; i < n; i++) begin
                        @(negedge clk);
                        rx_valid = 1'b1;
                        rx_data  = img[o+i] ^ ((bad && (o + i == 5)) ? 8'h01 : 8'h00);
                    end
                    @(negedge clk);
                    rx_valid = 1'b0;
                    txn_busy = 1'b0;
                end
            end
        end
    end

    // Build an image: fields, slot clock words per mask, valid sum byte.
    task automatic build_img(input int ver, input int rev, input int feat,
                             input int mask, input int hi_byte);
        int s8;
        for (int i = 0; i < BLK; i++) img[i] = 8'((i * 7 + 3) & 8'hFF);
        img[18] = 8'(ver);
        img[19] = 8'(rev);
        img[24] = feat ? 8'h0A : 8'h08;
        for (int s = 0; s < 4; s++) begin
            int b = 54 + 18 * s;
            if ((mask >> s) & 1) begin
                img[b]   = hi_byte ? 8'h00 : 8'h5C;
                img[b+1] = hi_byte ? 8'h21 : 8'h00;
            end else begin
                img[b]   = 8'h00;
                img[b+1] = 8'h00;
            end
        end
        s8 = 0;
        for (int i = 0; i < BLK - 1; i++) s8 = s8 + int'(img[i]);
        img[BLK-1] = 8'((256 - (s8 % 256)) % 256);
        cur_ver = ver; cur_rev = rev; cur_feat = feat; cur_mask = mask;
    endtask

    // One fetch with per-attempt fault masks; expected values from R4-R8.
    task automatic run_case(input logic [2:0] hm, input logic [2:0] bm, input string tag);
        int exp_starts = 0, exp_err = 0, exp_code = 0, exp_slot = 0, cause = 0, w = 0;
        bit ok = 1'b0;
        @(negedge clk);
        hang_mask = hm; bad_mask = bm;
        latt = 0; mon_att = 0; exp_off = 0; starts = 0; dones = 0; hang_gap = -1;
        for (int a = 0; a < 3; a++) begin
            if (hm[a]) begin exp_starts += 1; cause = 0; end
            else begin
                exp_starts += NCHUNK;
                if (bm[a]) cause = 1;
                else begin ok = 1'b1; break; end
            end
        end
        if (!ok) begin exp_err = 1; exp_code = cause; end
        else if (!(cur_ver == 1 && (cur_rev >= 3 || cur_feat != 0))) begin exp_err = 1; exp_code = 2; end
        else if (cur_mask == 0) begin exp_err = 1; exp_code = 3; end
        else begin
            for (int s = 3; s >= 0; s--) if ((cur_mask >> s) & 1) exp_slot = s;
        end
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (20) @(negedge clk);
        go = 1'b1;                     // R10: must be ignored mid-fetch
        @(negedge clk);
        go = 1'b0;
        while (dones == 0 && w < 5000) begin @(negedge clk); w++; end
        repeat (3) @(negedge clk);
        chk(dones == 1, {"R8 single done ", tag}, dones, 1);
        chk(starts == exp_starts, {"R5 R10 transaction count ", tag}, starts, exp_starts);
        chk(int'(d_err) == exp_err, {"R8 err ", tag}, int'(d_err), exp_err);
        chk(int'(d_code) == exp_code, {"R6 R7 err_code ", tag}, int'(d_code), exp_code);
        chk(int'(d_slot) == exp_slot, {"R7 slot_idx ", tag}, int'(d_slot), exp_slot);
        if (hm != 3'b000)
            chk(hang_gap == TMO + 1, {"R4 stall distance ", tag}, hang_gap, TMO + 1);
    endtask

    initial begin
        build_img(1, 3, 0, 1, 0);
        repeat (3) @(negedge clk);
        chk(!done && !fifo_clr && !txn_start, "R8 reset state",
            int'({done, fifo_clr, txn_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !fifo_clr && !txn_start, "R8 idle after reset",
            int'({done, fifo_clr, txn_start}), 0);

        // R7: every slot pattern, live word in low or high byte.
        for (int hb = 0; hb < 2; hb++)
            for (int m = 0; m < 16; m++) begin
                build_img(1, 3, 0, m, hb);
                run_case(3'b000, 3'b000, "R7 slot sweep");
            end

        // R6: version / revision / feature sweep.
        for (int v = 0; v < 3; v++)
            for (int r = 0; r < 5; r++)
                for (int f = 0; f < 2; f++) begin
                    build_img(v, r, f, 4'b0100, 0);
                    run_case(3'b000, 3'b000, "R6 version sweep");
                end

        // R5: sum failures and retry limit.
        build_img(1, 4, 0, 4'b1000, 1);
        run_case(3'b000, 3'b001, "R5 one bad");
        run_case(3'b000, 3'b011, "R5 two bad");
        run_case(3'b000, 3'b111, "R5 three bad");

        // R4: stalls, mixed with sum failures.
        run_case(3'b001, 3'b000, "R4 stall then good");
        run_case(3'b111, 3'b000, "R4 all stall");
        run_case(3'b011, 3'b100, "R4 R5 stall stall bad");
        run_case(3'b100, 3'b011, "R4 R5 bad bad stall");

        // R9: readback of the last good block.
        build_img(1, 3, 1, 4'b0010, 0);
        run_case(3'b000, 3'b000, "R9 prep");
        for (int a = 0; a < BLK; a++) begin
            rd_addr = 7'(a);
            @(negedge clk);
            chk(rd_data == img[a], "R9 buffer readback", int'(rd_data), int'(img[a]));
        end

        summary();
    end
endmodule